// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the processor-facing register port of a three-channel interval timer. A narrow byte bus with a 2-bit address reaches one data port per counter channel and one shared control port. Writes to the control port either set up a channel or take a snapshot of its count. The channel setup covers its counting mode, its decimal-count flag and its byte access format. Writes to a data port are assembled into 16-bit initial counts, and each complete count is handed to the channel with a one-cycle load strobe.

Reads of a data port return the channel's count one byte at a time. They follow the channel's access format and return the snapshot while one is held, otherwise the live count. The counting channels sit outside this block. They deliver their live counts on `cnt_i` and receive `load_o`, `load_val_o`, `mode_o`, `bcd_o` and `ctrl_wr_o`.

Top module: `ivt_host_port`

## Requirements
- R1: Address 0, 1 and 2 reach the data ports of channels 0, 1 and 2, and address 3 is the control port. `rdata_o` is 0 whenever `rd_en_i` is low or `addr_i` is 3. A read returns its byte combinationally in the same cycle, and the edge that ends the read advances the read state.
- R2: A control-port write sets up a channel when bits 5:4 are non-zero. Bits 7:6 select the channel (00, 01 or 10). Bits 5:4 set the access format (01 low byte only, 10 high byte only, 11 low then high). Bits 3:1 set the mode and bit 0 sets the decimal flag. In the next cycle the channel's `mode_o` and `bcd_o` fields show the new values, `ctrl_wr_o` pulses for one cycle on that channel, and no other channel changes.
- R3: A control-port write with bits 7:6 equal to 11 changes nothing in any channel.
- R4: In low-then-high format, the first data write stores the low byte and issues no load. The second write causes `load_o` to pulse for one cycle in the following cycle, with `load_val_o` = {second byte, first byte}.
- R5: In low-only format each data write loads {8'h00, byte}. In high-only format each data write loads {byte, 8'h00}. The load pulses in the cycle after the write.
- R6: Data-port reads follow the access format. Low-only returns bits 7:0, high-only returns bits 15:8, and low-then-high alternates, starting with bits 7:0.
- R7: A control-port write with bits 5:4 equal to 00 is a latch command. It captures the selected channel's `cnt_i` at that edge and leaves the mode, flag, format and byte toggles unchanged. Reads then return the captured value instead of the live count.
- R8: A snapshot is released by the read that completes a byte sequence. In low-only and high-only formats this is the next read. In low-then-high format it is the read of the high byte. After that, reads return the live count.
- R9: A latch command for a channel that already holds a snapshot is ignored.
- R10: A setup control word returns both the write toggle and the read toggle of its channel to the low byte, and it discards any held snapshot.
- R11: After reset every channel has mode 0, decimal flag 0 and low-then-high format. Both toggles point at the low byte and no snapshot is held. `load_o`, `ctrl_wr_o` and `load_val_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Port select: 0..2 data ports, 3 control port |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| cnt_i | input | 48 | Live counts of the channels, channel c at bits 16c+15:16c |
| load_o | output | 3 | One-cycle load strobe per channel |
| load_val_o | output | 48 | Assembled initial count per channel, held between loads |
| mode_o | output | 9 | Mode per channel, channel c at bits 3c+2:3c |
| bcd_o | output | 3 | Decimal-count flag per channel |
| ctrl_wr_o | output | 3 | One-cycle pulse per channel after a setup word |

## Verification
A wrong write toggle shows up on the next completed count: the load arrives one write early or late, or its bytes are swapped in `load_val_o`, one cycle after the write that should have finished the count. A wrong read toggle or a stale snapshot flag shows up in the first following read, because `rdata_o` then returns the wrong half or a frozen value while the live count has moved on. The bench makes `cnt_i` move every cycle so that a snapshot and the live value never agree for long. A decoding error in the control port reaches `mode_o`, `bcd_o` or `ctrl_wr_o` in the very next cycle, either on the addressed channel or on a channel that should have stayed untouched.

// File: rtl/ivt_host_pkg.sv
package ivt_host_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  // bit layout of a control word, msb first
  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } cw_t;
endpackage

// File: rtl/ivt_cw_decode.sv
module ivt_cw_decode
  import ivt_host_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = $clog2(NCH + 1)
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output cw_t               cw_o,
  output logic [NCH-1:0]    cfg_we_o,
  output logic [NCH-1:0]    latch_req_o,
  output logic [NCH-1:0]    data_we_o,
  output logic [NCH-1:0]    data_re_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic ctrl_wr;
  assign cw_o    = cw_t'(wdata_i);
  assign ctrl_wr = wr_en_i && (addr_i == CTRL_ADDR);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    // select 2'b11 never matches a channel index, so it falls through
    assign hit            = ctrl_wr && (cw_o.sel == 2'(c));
    assign cfg_we_o[c]    = hit && (cw_o.acc != ACC_LATCH);
    assign latch_req_o[c] = hit && (cw_o.acc == ACC_LATCH);
    assign data_we_o[c]   = wr_en_i && (addr_i == AW'(c));
    assign data_re_o[c]   = rd_en_i && (addr_i == AW'(c));
  end
endmodule

// File: rtl/ivt_chan_regs.sv
module ivt_chan_regs
  import ivt_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  cw_t               cw_i,
  input  logic              latch_req_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              data_re_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o,
  output logic              ctrl_wr_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  acc_e              acc_q;
  logic              wr_hi_q;
  logic              rd_hi_q;
  logic              lat_vld_q;
  logic [BYTE_W-1:0] lo_hold_q;
  logic [CNT_W-1:0]  lat_q;
  logic [CNT_W-1:0]  rd_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= '0;
      bcd_o      <= 1'b0;
      acc_q      <= ACC_WORD;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      lat_vld_q  <= 1'b0;
      lo_hold_q  <= '0;
      lat_q      <= '0;
      ctrl_wr_o  <= 1'b0;
      load_o     <= 1'b0;
      load_val_o <= '0;
    end else begin
      ctrl_wr_o <= 1'b0;
      load_o    <= 1'b0;
      if (cfg_we_i) begin
        mode_o    <= cw_i.mode;
        bcd_o     <= cw_i.bcd;
        acc_q     <= cw_i.acc;
        wr_hi_q   <= 1'b0;
        rd_hi_q   <= 1'b0;
        lat_vld_q <= 1'b0;
        ctrl_wr_o <= 1'b1;
      end else begin
        if (latch_req_i && !lat_vld_q) begin
          lat_vld_q <= 1'b1;
          lat_q     <= cnt_i;
        end
        if (data_we_i) begin
          unique case (acc_q)
            ACC_LO: begin
              load_val_o <= {{BYTE_W{1'b0}}, wdata_i};
              load_o     <= 1'b1;
            end
            ACC_HI: begin
              load_val_o <= {wdata_i, {BYTE_W{1'b0}}};
              load_o     <= 1'b1;
            end
            ACC_WORD: begin
              if (!wr_hi_q) begin
                lo_hold_q <= wdata_i;
                wr_hi_q   <= 1'b1;
              end else begin
                load_val_o <= {wdata_i, lo_hold_q};
                load_o     <= 1'b1;
                wr_hi_q    <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (data_re_i) begin
          // snapshot ends with the read that completes the byte sequence
          if (lat_vld_q && ((acc_q != ACC_WORD) || rd_hi_q)) lat_vld_q <= 1'b0;
          if (acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
        end
      end
    end
  end

  assign rd_src = lat_vld_q ? lat_q : cnt_i;

  always_comb begin
    unique case (acc_q)
      ACC_HI:   rd_byte_o = rd_src[CNT_W-1:BYTE_W];
      ACC_WORD: rd_byte_o = rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
      default:  rd_byte_o = rd_src[BYTE_W-1:0];
    endcase
  end
endmodule

// File: rtl/ivt_rd_mux.sv
module ivt_rd_mux
  import ivt_host_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = $clog2(NCH + 1)
) (
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [NCH*BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0]     rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_en_i && (addr_i == AW'(c))) rdata_o = byte_i[c*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ivt_host_port.sv
module ivt_host_port
  import ivt_host_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = $clog2(NCH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  wr_en_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  rd_en_i,
  output logic [BYTE_W-1:0]     rdata_o,
  input  logic [NCH*CNT_W-1:0]  cnt_i,
  output logic [NCH-1:0]        load_o,
  output logic [NCH*CNT_W-1:0]  load_val_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH-1:0]        bcd_o,
  output logic [NCH-1:0]        ctrl_wr_o
);
  cw_t                   cw;
  logic [NCH-1:0]        cfg_we;
  logic [NCH-1:0]        latch_req;
  logic [NCH-1:0]        data_we;
  logic [NCH-1:0]        data_re;
  logic [NCH*BYTE_W-1:0] rd_bytes;

  ivt_cw_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cw_o       (cw),
    .cfg_we_o   (cfg_we),
    .latch_req_o(latch_req),
    .data_we_o  (data_we),
    .data_re_o  (data_re)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ivt_chan_regs u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we[c]),
      .cw_i       (cw),
      .latch_req_i(latch_req[c]),
      .data_we_i  (data_we[c]),
      .wdata_i    (wdata_i),
      .data_re_i  (data_re[c]),
      .cnt_i      (cnt_i[c*CNT_W +: CNT_W]),
      .mode_o     (mode_o[c*MODE_W +: MODE_W]),
      .bcd_o      (bcd_o[c]),
      .ctrl_wr_o  (ctrl_wr_o[c]),
      .load_o     (load_o[c]),
      .load_val_o (load_val_o[c*CNT_W +: CNT_W]),
      .rd_byte_o  (rd_bytes[c*BYTE_W +: BYTE_W])
    );
  end

  ivt_rd_mux #(.NCH(NCH), .AW(AW)) u_mux (
    .rd_en_i(rd_en_i),
    .addr_i (addr_i),
    .byte_i (rd_bytes),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/ivt_host_port_chk.sv
module ivt_host_port_chk
  import ivt_host_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = $clog2(NCH + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [AW-1:0]         addr_i,
  input logic                  wr_en_i,
  input logic [BYTE_W-1:0]     wdata_i,
  input logic                  rd_en_i,
  input logic [BYTE_W-1:0]     rdata_o,
  input logic [NCH*CNT_W-1:0]  cnt_i,
  input logic [NCH-1:0]        load_o,
  input logic [NCH*CNT_W-1:0]  load_val_o,
  input logic [NCH*MODE_W-1:0] mode_o,
  input logic [NCH-1:0]        bcd_o,
  input logic [NCH-1:0]        ctrl_wr_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  assert_ctrl_read_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == CTRL_ADDR) |-> rdata_o == '0);

  assert_reserved_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CTRL_ADDR && wdata_i[7:6] == 2'b11)
      |=> ($stable(mode_o) && $stable(bcd_o) && ctrl_wr_o == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_load_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[c] |-> $past(wr_en_i && addr_i == AW'(c)));

    assert_ctrl_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr_o[c] |-> $past(wr_en_i && addr_i == CTRL_ADDR &&
                             wdata_i[7:6] == 2'(c) && wdata_i[5:4] != 2'b00));

    assert_mode_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr_o[c] |-> (mode_o[c*MODE_W +: MODE_W] == $past(wdata_i[3:1]) &&
                        bcd_o[c] == $past(wdata_i[0])));

    assert_latch_keeps_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == CTRL_ADDR && wdata_i[7:6] == 2'(c) && wdata_i[5:4] == 2'b00)
        |=> ($stable(mode_o[c*MODE_W +: MODE_W]) && $stable(bcd_o[c]) && !ctrl_wr_o[c]));
  end
endmodule

bind ivt_host_port ivt_host_port_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/tb_ivt_host_port.sv
`timescale 1ns/1ps
module tb_ivt_host_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [47:0] cnt_i;
  logic [2:0]  load_o;
  logic [47:0] load_val_o;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;
  logic [2:0]  ctrl_wr_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  logic [15:0] cnt [3];
  // reference model state
  int m_mode [3], m_bcd [3], m_acc [3], m_wptr [3], m_rptr [3], m_lvld [3];
  logic [15:0] m_lq [3];
  logic [7:0]  m_lo [3];
  logic [15:0] e_val [3];
  logic        e_load [3], e_ctrl [3];

  assign cnt_i = {cnt[2], cnt[1], cnt[0]};

  always #2.5 clk_i = ~clk_i;

  ivt_host_port dut (.*);

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic cmp_regs();
    for (int c = 0; c < 3; c++) begin
      chk($sformatf("load_o[%0d]", c), int'(load_o[c]), int'(e_load[c]));
      chk($sformatf("load_val[%0d]", c), int'(load_val_o[c*16 +: 16]), int'(e_val[c]));
      chk($sformatf("mode[%0d]", c), int'(mode_o[c*3 +: 3]), m_mode[c]);
      chk($sformatf("bcd[%0d]", c), int'(bcd_o[c]), m_bcd[c]);
      chk($sformatf("ctrl_wr[%0d]", c), int'(ctrl_wr_o[c]), int'(e_ctrl[c]));
    end
  endtask

  task automatic model_edge(input logic we, input logic re, input int a, input logic [7:0] d);
    for (int c = 0; c < 3; c++) begin e_load[c] = 0; e_ctrl[c] = 0; end
    if (we && a == 3) begin
      int s = int'(d[7:6]);
      if (s != 3) begin
        if (d[5:4] == 2'b00) begin
          if (m_lvld[s] == 0) begin m_lvld[s] = 1; m_lq[s] = cnt[s]; end
        end else begin
          m_mode[s] = int'(d[3:1]); m_bcd[s] = int'(d[0]); m_acc[s] = int'(d[5:4]);
          m_wptr[s] = 0; m_rptr[s] = 0; m_lvld[s] = 0; e_ctrl[s] = 1;
        end
      end
    end
    if (we && a < 3) begin
      if (m_acc[a] == 1) begin e_val[a] = {8'h00, d}; e_load[a] = 1; end
      else if (m_acc[a] == 2) begin e_val[a] = {d, 8'h00}; e_load[a] = 1; end
      else if (m_wptr[a] == 0) begin m_lo[a] = d; m_wptr[a] = 1; end
      else begin e_val[a] = {d, m_lo[a]}; e_load[a] = 1; m_wptr[a] = 0; end
    end
    if (re && a < 3) begin
      if (m_lvld[a] != 0 && (m_acc[a] != 3 || m_rptr[a] == 1)) m_lvld[a] = 0;
      if (m_acc[a] == 3) m_rptr[a] = 1 - m_rptr[a];
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic re, input int a);
    logic [15:0] src;
    if (!re || a > 2) return 8'h00;
    src = (m_lvld[a] != 0) ? m_lq[a] : cnt[a];
    if (m_acc[a] == 1) return src[7:0];
    if (m_acc[a] == 2) return src[15:8];
    return (m_rptr[a] == 1) ? src[15:8] : src[7:0];
  endfunction

  task automatic step(input logic we, input logic re, input int a, input logic [7:0] d);
    @(negedge clk_i);
    cmp_regs();
    wr_en_i = we; rd_en_i = re; addr_i = 2'(a); wdata_i = d;
    for (int c = 0; c < 3; c++) cnt[c] = cnt[c] - 16'(c + 1) * 16'h0107;
    #1;
    chk("rdata", int'(rdata_o), int'(exp_rd(re, a)));
    @(posedge clk_i);
    model_edge(we, re, a, d);
  endtask

  task automatic wr(input int a, input logic [7:0] d); step(1'b1, 1'b0, a, d); endtask
  task automatic rd(input int a); step(1'b0, 1'b1, a, 8'h00); endtask
  task automatic idle(); step(1'b0, 1'b0, 0, 8'h00); endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      cnt[c] = 16'h8421 + 16'(c) * 16'h1111;
      m_mode[c] = 0; m_bcd[c] = 0; m_acc[c] = 3; m_wptr[c] = 0; m_rptr[c] = 0;
      m_lvld[c] = 0; m_lq[c] = '0; m_lo[c] = '0; e_val[c] = '0; e_load[c] = 0; e_ctrl[c] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R11 reset state
    cur_req = "R11"; idle(); idle();
    // R6 live reads in default word format: low then high
    cur_req = "R6"; rd(0); rd(0); rd(0); idle();
    // R4 word-format count assembly
    cur_req = "R4"; wr(1, 8'h34); idle(); wr(1, 8'h12); idle(); wr(1, 8'hCD); wr(1, 8'hAB); idle();
    // R2 setup words: ch2 mode 5 bcd low-only; ch0 mode 3 high-only
    cur_req = "R2"; wr(3, 8'h9B); idle(); wr(3, 8'h26); idle();
    // R5 single-byte formats
    cur_req = "R5"; wr(2, 8'h77); idle(); wr(0, 8'hAB); wr(0, 8'h5C); idle();
    cur_req = "R6"; rd(2); rd(2); rd(0); rd(0); idle();
    // R3 reserved select
    cur_req = "R3"; wr(3, 8'hFF); idle(); wr(3, 8'hC4); idle();
    // R1 control port reads zero, idle bus reads zero
    cur_req = "R1"; rd(3); idle(); rd(1); idle();
    // R7 latch in word format, R9 second latch ignored, R8 release after high byte
    cur_req = "R7"; wr(3, 8'h40); idle(); idle();
    cur_req = "R9"; wr(3, 8'h40); idle();
    cur_req = "R8"; rd(1); idle(); rd(1); rd(1); rd(1); idle();
    // R7 latch in low-only format, R8 release after one read
    cur_req = "R7"; wr(3, 8'h80); idle(); idle();
    cur_req = "R8"; rd(2); rd(2); idle();
    // R7 latch in high-only format
    cur_req = "R7"; wr(3, 8'h00); idle();
    cur_req = "R8"; rd(0); rd(0); idle();
    // R10 setup word resets toggles and drops snapshot
    cur_req = "R10"; wr(1, 8'h55); rd(1); wr(3, 8'h40); idle();
    wr(3, 8'h74); idle(); wr(1, 8'h11); wr(1, 8'h22); idle(); rd(1); rd(1); idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule